// File: doc/BRIEF.md
# Camera Capture Interrupt Status Unit

This block holds the five raw interrupt status flags of a parallel camera capture port. Two of them come from the sync lines. Frame sync and line sync arrive as levels, each with a selectable active polarity. Each level passes through a synchronizer, and a flag is raised on every inactive-to-active transition. The other three come from single-cycle event pulses produced elsewhere in the capture path: capture complete (a whole frame or a crop window, even an empty one), data FIFO overrun, and embedded sync code ordering error.

Synchronization mode and the capture enable qualify the events. In embedded mode the two sync flags can only rise while capture is enabled. In hardware-sync mode the ordering-error pulse is ignored. Software clears flags by writing ones to a clear strobe. The block also drives one registered interrupt line, which is the OR of the flags that are enabled.

Top module: `cam_irq_status`

## Requirements
- R1: While `rst` is high at a rising edge, every flag in `raw_flags` and `irq` read 0 after that edge.
- R2: A one-cycle `frame_done` pulse sets `raw_flags[0]` at the next edge, whatever the mode and capture enable (an empty crop window still produces the pulse).
- R3: An `overrun` pulse sets `raw_flags[1]` at the next edge.
- R4: A `sync_err` pulse sets `raw_flags[2]` at the next edge only when `embedded_mode` is 1. When `embedded_mode` is 0 the pulse leaves the flag unchanged.
- R5: An inactive-to-active transition of `vsync_in` sets `raw_flags[3]`. With the default two synchronizer stages, a change that is present before rising edge 1 shows up in the flag after rising edge 3, and not after edge 2.
- R6: An inactive-to-active transition of `hsync_in` sets `raw_flags[4]` with the same latency as R5. There is no check on whether the line is valid. An active-to-inactive transition sets nothing.
- R7: When `embedded_mode` is 1 and `capture_en` is 0, sync transitions do not set `raw_flags[3]` or `raw_flags[4]`. When `embedded_mode` is 0, `capture_en` has no effect on those flags.
- R8: At an edge where `clr_wr` is 1, each flag whose bit in `clr_data` is 1 is cleared. Flags whose `clr_data` bit is 0 keep their value. When `clr_wr` is 0, nothing is cleared.
- R9: When a set event and a clear of the same flag occur in the same cycle, the flag is 1 afterwards.
- R10: `irq` equals the OR over i of (`raw_flags[i]` AND `irq_en[i]`), as it stood one cycle earlier.
- R11: `vsync_pol` and `hsync_pol` select the active level of each sync line: 1 means active high and 0 means active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_in | input | 1 | Frame sync level (asynchronous) |
| hsync_in | input | 1 | Line sync level (asynchronous) |
| vsync_pol | input | 1 | Active level of frame sync (1 = high) |
| hsync_pol | input | 1 | Active level of line sync (1 = high) |
| frame_done | input | 1 | Pulse: frame or crop window captured |
| overrun | input | 1 | Pulse: data FIFO overflowed |
| sync_err | input | 1 | Pulse: embedded sync codes out of order |
| embedded_mode | input | 1 | 1 = embedded sync, 0 = hardware sync lines |
| capture_en | input | 1 | Capture enable |
| clr_wr | input | 1 | Clear register write strobe |
| clr_data | input | 5 | Write-one-to-clear mask, same bit order as `raw_flags` |
| irq_en | input | 5 | Interrupt enable mask, same bit order as `raw_flags` |
| raw_flags | output | 5 | Bit 0 capture done, 1 overrun, 2 sync error, 3 frame sync, 4 line |
| irq | output | 1 | Registered combined interrupt |

## Verification
The assertions assume that the three event inputs and the clear strobe are synchronous to `clk`, and that the sync levels are held at their inactive level while reset is applied. Without that, the first edge after reset could report a transition that never happened. They also assume that mode and capture enable are sampled at the same edge as the event they qualify. The stimulus drives every input on the falling edge. It keeps the sync lines inactive during reset and changes a polarity only while the matching line is being flushed through before a clear. The random phase toggles the sync levels and pulses at moderate rates, so rising edges, falling edges, same-cycle set/clear collisions and mode changes all occur.

// File: rtl/cam_irq_pkg.sv
package cam_irq_pkg;
  localparam int NUM_FLAGS = 5;
  localparam int FL_FRAME  = 0;
  localparam int FL_OVR    = 1;
  localparam int FL_ERR    = 2;
  localparam int FL_VSYNC  = 3;
  localparam int FL_LINE   = 4;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/cis_level_sync.sv
module cis_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  input  logic active_pol,
  output logic rise_pulse
);
  localparam int LAST = STAGES - 1;

  logic             active_raw;
  logic [LAST:0]    chain;
  logic             prev_act;

  // normalise to "active" before synchronising, so reset state is inactive
  assign active_raw = level_in ~^ active_pol;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain    <= '0;
      prev_act <= 1'b0;
    end else begin
      chain    <= {chain[LAST-1:0], active_raw};
      prev_act <= chain[LAST];
    end
  end

  assign rise_pulse = chain[LAST] & ~prev_act;

  // R5/R6: one transition produces one pulse, never two in a row
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/cis_event_qual.sv
module cis_event_qual
  import cam_irq_pkg::*;
(
  input  logic      vsync_rise,
  input  logic      hsync_rise,
  input  logic      frame_done,
  input  logic      overrun,
  input  logic      sync_err,
  input  logic      embedded_mode,
  input  logic      capture_en,
  output flag_vec_t set_vec
);
  logic sync_ok;

  // in embedded mode, sync-derived flags need capture running
  assign sync_ok = ~embedded_mode | capture_en;

  always_comb begin
    set_vec           = '0;
    set_vec[FL_FRAME] = frame_done;
    set_vec[FL_OVR]   = overrun;
    set_vec[FL_ERR]   = sync_err & embedded_mode;
    set_vec[FL_VSYNC] = vsync_rise & sync_ok;
    set_vec[FL_LINE]  = hsync_rise & sync_ok;
  end
endmodule

// File: rtl/cis_flag_bank.sv
module cis_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_mask : '0;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)              flags[i] <= 1'b0;
      else if (set_vec[i])  flags[i] <= 1'b1;   // set beats clear
      else if (clr_eff[i])  flags[i] <= 1'b0;
    end

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> flags[i]);
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_wr && clr_mask[i] && !set_vec[i]) |=> !flags[i]);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      (!set_vec[i] && !(clr_wr && clr_mask[i])) |=> $stable(flags[i]));
  end
endmodule

// File: rtl/cis_irq_gate.sv
module cis_irq_gate #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enable,
  output logic         irq
);
  logic pending;

  assign pending = |(flags & enable);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= pending;
  end

  a_r10_irq_follows: assert property (@(posedge clk) disable iff (rst)
    pending |=> irq);
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    !pending |=> !irq);
endmodule

// File: rtl/cam_irq_status.sv
module cam_irq_status
  import cam_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vsync_in,
  input  logic                 hsync_in,
  input  logic                 vsync_pol,
  input  logic                 hsync_pol,
  input  logic                 frame_done,
  input  logic                 overrun,
  input  logic                 sync_err,
  input  logic                 embedded_mode,
  input  logic                 capture_en,
  input  logic                 clr_wr,
  input  logic [NUM_FLAGS-1:0] clr_data,
  input  logic [NUM_FLAGS-1:0] irq_en,
  output logic [NUM_FLAGS-1:0] raw_flags,
  output logic                 irq
);
  logic      vsync_rise;
  logic      hsync_rise;
  flag_vec_t set_vec;

  cis_level_sync #(.STAGES(SYNC_STAGES)) u_vsync (
    .clk(clk), .rst(rst), .level_in(vsync_in), .active_pol(vsync_pol),
    .rise_pulse(vsync_rise));

  cis_level_sync #(.STAGES(SYNC_STAGES)) u_hsync (
    .clk(clk), .rst(rst), .level_in(hsync_in), .active_pol(hsync_pol),
    .rise_pulse(hsync_rise));

  cis_event_qual u_qual (
    .vsync_rise(vsync_rise), .hsync_rise(hsync_rise),
    .frame_done(frame_done), .overrun(overrun), .sync_err(sync_err),
    .embedded_mode(embedded_mode), .capture_en(capture_en),
    .set_vec(set_vec));

  cis_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_wr(clr_wr),
    .clr_mask(clr_data), .flags(raw_flags));

  cis_irq_gate #(.N(NUM_FLAGS)) u_irq (
    .clk(clk), .rst(rst), .flags(raw_flags), .enable(irq_en), .irq(irq));

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (raw_flags == '0) && !irq);
  a_r2_frame_any_mode: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> raw_flags[FL_FRAME]);
  a_r3_overrun: assert property (@(posedge clk) disable iff (rst)
    overrun |=> raw_flags[FL_OVR]);
  a_r4_hw_no_err: assert property (@(posedge clk) disable iff (rst)
    (!embedded_mode && !raw_flags[FL_ERR]) |=> !raw_flags[FL_ERR]);
  a_r7_gated_vsync: assert property (@(posedge clk) disable iff (rst)
    (embedded_mode && !capture_en && !raw_flags[FL_VSYNC]) |=> !raw_flags[FL_VSYNC]);
  a_r7_gated_line: assert property (@(posedge clk) disable iff (rst)
    (embedded_mode && !capture_en && !raw_flags[FL_LINE]) |=> !raw_flags[FL_LINE]);
endmodule

// File: tb/cam_irq_status_bench.sv
module cam_irq_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int N          = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vsync_in = 1'b0, hsync_in = 1'b0, vsync_pol = 1'b1, hsync_pol = 1'b1;
  logic frame_done = 1'b0, overrun = 1'b0, sync_err = 1'b0;
  logic embedded_mode = 1'b0, capture_en = 1'b0, clr_wr = 1'b0;
  logic [N-1:0] clr_data = '0, irq_en = '1;
  logic [N-1:0] raw_flags;
  logic irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_irq_status u_cam_irq_status (
    .clk(clk), .rst(rst), .vsync_in(vsync_in), .hsync_in(hsync_in),
    .vsync_pol(vsync_pol), .hsync_pol(hsync_pol), .frame_done(frame_done),
    .overrun(overrun), .sync_err(sync_err), .embedded_mode(embedded_mode),
    .capture_en(capture_en), .clr_wr(clr_wr), .clr_data(clr_data),
    .irq_en(irq_en), .raw_flags(raw_flags), .irq(irq));

  // ---------------- reference model built from the requirements
  logic [2:0]   mv = '0, mh = '0;   // active-level history, 3-edge latency (R5/R6)
  logic [N-1:0] mflags = '0;
  logic         mirq = 1'b0;

  function automatic logic [N-1:0] exp_set(logic vr, logic hr, logic fd, logic ov,
                                            logic se, logic em, logic ce);
    logic ok;
    ok = !em || ce;                         // R7
    return {hr && ok, vr && ok, se && em, ov, fd};   // R6 R5 R4 R3 R2
  endfunction

  function automatic logic [N-1:0] exp_next(logic [N-1:0] cur, logic [N-1:0] s,
                                            logic cw, logic [N-1:0] cd);
    return s | (cur & ~(cw ? cd : '0));     // R8, R9
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mv <= '0; mh <= '0; mflags <= '0; mirq <= 1'b0;
    end else begin
      mv     <= {mv[1:0], vsync_in ~^ vsync_pol};   // R11
      mh     <= {mh[1:0], hsync_in ~^ hsync_pol};
      mflags <= exp_next(mflags,
                  exp_set(mv[1] & ~mv[2], mh[1] & ~mh[2], frame_done, overrun,
                          sync_err, embedded_mode, capture_en),
                  clr_wr, clr_data);
      mirq   <= |(mflags & irq_en);                 // R10
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp_v, $time);
    end
  endtask

  function automatic string tag_of(int b);
    case (b)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done && !rst) begin
      for (int b = 0; b < N; b++)
        check(raw_flags[b] === mflags[b], tag_of(b), raw_flags[b], mflags[b]);
      check(irq === mirq, "R10", irq, mirq);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_wr = 1'b1; clr_data = '1;
    step();
    clr_wr = 1'b0; clr_data = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    check(raw_flags == '0, "R1", raw_flags, 0);
    check(irq == 1'b0, "R1", irq, 0);
    rst = 1'b0;
    step();

    // R2: capture-done in embedded mode with capture disabled (empty window)
    embedded_mode = 1'b1; capture_en = 1'b0; frame_done = 1'b1;
    step(); frame_done = 1'b0;
    check(raw_flags[0] == 1'b1, "R2", raw_flags[0], 1);
    step();
    check(irq == 1'b1, "R10", irq, 1);

    // R8: clear only bit 0, then irq drops a cycle later
    overrun = 1'b1; step(); overrun = 1'b0;
    check(raw_flags[1] == 1'b1, "R3", raw_flags[1], 1);
    clr_wr = 1'b1; clr_data = 5'b00001; step(); clr_wr = 1'b0; clr_data = '0;
    check(raw_flags == 5'b00010, "R8", raw_flags, 5'b00010);
    clr_data = 5'b00010; step();   // data without strobe clears nothing
    check(raw_flags == 5'b00010, "R8", raw_flags, 5'b00010);
    clr_data = '0;
    clear_all(); step();
    check(irq == 1'b0, "R10", irq, 0);

    // R4: sync error ignored in hardware mode, taken in embedded mode
    embedded_mode = 1'b0; sync_err = 1'b1; step(); sync_err = 1'b0;
    check(raw_flags[2] == 1'b0, "R4", raw_flags[2], 0);
    embedded_mode = 1'b1; sync_err = 1'b1; step(); sync_err = 1'b0;
    check(raw_flags[2] == 1'b1, "R4", raw_flags[2], 1);
    clear_all();

    // R7: embedded, capture off -> no frame sync flag
    capture_en = 1'b0; vsync_in = 1'b1; step(5);
    check(raw_flags[3] == 1'b0, "R7", raw_flags[3], 0);
    vsync_in = 1'b0; step(4);
    // R5 latency with capture on
    capture_en = 1'b1; vsync_in = 1'b1; step(2);
    check(raw_flags[3] == 1'b0, "R5", raw_flags[3], 0);
    step();
    check(raw_flags[3] == 1'b1, "R5", raw_flags[3], 1);
    clear_all();

    // R7: hardware mode ignores capture enable; R6 line flag
    embedded_mode = 1'b0; capture_en = 1'b0; hsync_in = 1'b1; step(3);
    check(raw_flags[4] == 1'b1, "R7", raw_flags[4], 1);
    clear_all();
    hsync_in = 1'b0; step(5);      // falling transition sets nothing
    check(raw_flags[4] == 1'b0, "R6", raw_flags[4], 0);

    // R11: frame sync active low
    vsync_pol = 1'b0; step(5); clear_all();   // vsync_in=1 now inactive
    step(3);
    check(raw_flags[3] == 1'b0, "R11", raw_flags[3], 0);
    vsync_in = 1'b0; step(3);
    check(raw_flags[3] == 1'b1, "R11", raw_flags[3], 1);
    clear_all();

    // R9: set and clear of the same flag in one cycle
    overrun = 1'b1; clr_wr = 1'b1; clr_data = 5'b00010; step();
    overrun = 1'b0; clr_wr = 1'b0; clr_data = '0;
    check(raw_flags[1] == 1'b1, "R9", raw_flags[1], 1);
    clear_all();

    // random phase, checked by the model every cycle
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) vsync_in = ~vsync_in;
      if ($urandom_range(0, 2) == 0) hsync_in = ~hsync_in;
      frame_done    = ($urandom_range(0, 15) == 0);
      overrun       = ($urandom_range(0, 19) == 0);
      sync_err      = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 63) == 0) embedded_mode = ~embedded_mode;
      if ($urandom_range(0, 31) == 0) capture_en = ~capture_en;
      clr_wr        = ($urandom_range(0, 3) == 0);
      clr_data      = N'($urandom);
      if ($urandom_range(0, 99) == 0) irq_en = N'($urandom);
      step();
    end
    frame_done = 1'b0; overrun = 1'b0; sync_err = 1'b0; clr_wr = 1'b0;
    step(2);

    // reset mid-run clears everything (R1)
    rst = 1'b1; step();
    check(raw_flags == '0, "R1", raw_flags, 0);
    check(irq == 1'b0, "R1", irq, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule